// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one memory burst, one per clock. An accepted start pulse loads a start column, a burst length code, a burst order (sequential or interleave) and a read/write indication. Starting with the next cycle the block presents the start column as beat 0 and then advances beat by beat. For finite lengths only the low address bits covered by the burst length move, and they wrap inside that window. The higher bits stay where the start column put them. Full-page bursts walk the whole 10-bit row, wrap from the top column to column 0, and run until a stop request ends them.

A start that arrives while a burst runs throws away the rest of the old burst and begins a fresh one of full length at the new column. Stop requests in finite modes are not legal, so the block ignores them and reports them with a one-cycle error pulse. A suspend input freezes the whole sequence for every cycle it is held high. A configuration error flag reports reserved length codes and the unsupported combination of interleave with full page.

Top module: `colseq_gen`

## Requirements
- R1: One cycle after a start accepted with `susp_i` low, `valid_o` is 1 and `col_o` equals the start column (beat 0).
- R2: `len_code_i` selects the length: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. Codes 3'b100, 3'b101 and 3'b110 are reserved. They run a 1-beat burst and set `cfg_err_o` from the cycle after the start until the next accepted start.
- R3: With `ilv_i`=0 and finite length L, beat k shows the start column with its low log2(L) bits replaced by (start+k) mod L. No carry reaches the upper bits.
- R4: With `ilv_i`=1 and finite length L, beat k shows the start column with its low log2(L) bits XORed with k.
- R5: In full page, beat k shows (start+k) mod 1024. `last_o` never rises, and the burst keeps running until it is stopped.
- R6: `last_o` is high exactly on the final beat of a finite burst. Without suspend or a new start, `valid_o` is 0 in the following cycle.
- R7: A start during a running burst ends the old sequence. The next cycle shows the new start column, and a full burst of the newly given length follows.
- R8: A stop request during a full-page burst makes `valid_o` 0 in the next cycle.
- R9: A stop request during a finite burst does not change the sequence. `stop_err_o` is then high for one cycle, the cycle after the request. A stop request while idle does nothing.
- R10: If `wr_i` and `single_wr_i` are both 1 at the start, the burst is 1 beat long. A read (`wr_i`=0) keeps the programmed length.
- R11: Interleave with full page runs in sequential order and sets `cfg_err_o`.
- R12: While `susp_i` is high, the column, `valid_o` and the beat position hold, and start and stop requests are ignored.
- R13: After reset, `valid_o`, `last_o`, `stop_err_o` and `cfg_err_o` are 0 and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) a burst |
| start_col_i | input | 10 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 sequential, 1 interleave |
| wr_i | input | 1 | Start belongs to a write |
| single_wr_i | input | 1 | Force write bursts to one beat |
| stop_i | input | 1 | Stop request |
| susp_i | input | 1 | Freeze the sequence this cycle |
| col_o | output | 10 | Current column (0 when idle) |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of a finite burst |
| stop_err_o | output | 1 | Illegal stop seen (one-cycle pulse) |
| cfg_err_o | output | 1 | Current burst configuration was reserved |

## Verification
The bench sweeps every length code under both burst orders, using the 64 lowest and 64 highest start columns. The low columns show that the wrap stays inside the window and that the upper bits are kept. The high columns show that no carry spills across the top of the row. A full-page run longer than the row shows the wrap from column 1023 to 0 and confirms that the sequence never ends on its own. Directed sequences then apply a restart in mid-burst, a stop request in each mode and while idle, a suspend combined with start and stop requests, and single-write starts. These tell interruption, illegal-stop reporting and freezing apart from normal advance.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

   localparam logic [2:0] LEN_ONE   = 3'b000;
   localparam logic [2:0] LEN_TWO   = 3'b001;
   localparam logic [2:0] LEN_FOUR  = 3'b010;
   localparam logic [2:0] LEN_EIGHT = 3'b011;
   localparam logic [2:0] LEN_PAGE  = 3'b111;

   typedef struct packed {
      logic full;   // burst runs over whole row until stopped
      logic ilv;    // effective interleave order
      logic err;    // configuration was reserved
   } burst_mode_t;

endpackage

// File: rtl/colseq_cfg.sv
module colseq_cfg
   import colseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int LEN_W  = 3,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             ilv_i,
   input  logic             wr_i,
   input  logic             single_wr_i,
   output logic [COL_W-1:0] mask_o,
   output burst_mode_t      mode_o
);

   localparam int LOG_MAX = 3;

   logic [1:0] nlog;
   logic       page_code;
   logic       rsvd_code;
   logic       force_one;
   logic       full_eff;

   generate
      if (COL_W < LOG_MAX) begin : g_bad_width
         $error("colseq_cfg: COL_W must cover an eight-beat window");
      end
      if (LEN_W != 3) begin : g_bad_len
         $error("colseq_cfg: LEN_W must be 3");
      end
   endgenerate

   always_comb begin
      nlog      = 2'd0;
      page_code = 1'b0;
      rsvd_code = 1'b0;
      case (len_code_i)
         LEN_ONE:   nlog = 2'd0;
         LEN_TWO:   nlog = 2'd1;
         LEN_FOUR:  nlog = 2'd2;
         LEN_EIGHT: nlog = 2'd3;
         LEN_PAGE:  page_code = 1'b1;
         default:   rsvd_code = 1'b1;
      endcase
   end

   assign force_one = wr_i & single_wr_i;
   assign full_eff  = page_code & ~force_one;

   // window mask: low bits that move during the burst
   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      if (i < LOG_MAX) begin : g_low
         assign mask_o[i] = full_eff | (~force_one & (nlog > 2'(i)));
      end else begin : g_high
         assign mask_o[i] = full_eff;
      end
   end

   generate
      if (ILV_EN) begin : g_ilv
         assign mode_o.ilv = ilv_i & ~full_eff;
         assign mode_o.err = rsvd_code | (ilv_i & page_code);
      end else begin : g_seq_only
         assign mode_o.ilv = 1'b0;
         assign mode_o.err = rsvd_code | ilv_i;
      end
   endgenerate

   assign mode_o.full = full_eff;

endmodule

// File: rtl/colseq_ctl.sv
module colseq_ctl
   import colseq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [COL_W-1:0] mask_i,
   input  burst_mode_t      mode_i,
   input  logic             stop_i,
   input  logic             susp_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             ilv_o,
   output logic             last_o,
   output logic             stop_err_o,
   output logic             cfg_err_o
);

   logic             active_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   burst_mode_t      mode_q;
   logic             stop_err_q;
   logic             last_w;

   assign last_w = active_q & ~mode_q.full & (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         beat_q     <= '0;
         base_q     <= '0;
         mask_q     <= '0;
         mode_q     <= '0;
         stop_err_q <= 1'b0;
      end else begin
         stop_err_q <= 1'b0;
         if (!susp_i) begin
            if (start_i) begin
               active_q <= 1'b1;
               beat_q   <= '0;
               base_q   <= start_col_i;
               mask_q   <= mask_i;
               mode_q   <= mode_i;
            end else if (active_q) begin
               if (stop_i && mode_q.full) begin
                  active_q <= 1'b0;
               end else begin
                  if (stop_i) stop_err_q <= 1'b1;
                  if (last_w) active_q <= 1'b0;
                  else        beat_q   <= beat_q + COL_W'(1);
               end
            end
         end
      end
   end

   assign active_o   = active_q;
   assign beat_o     = beat_q;
   assign base_o     = base_q;
   assign mask_o     = mask_q;
   assign ilv_o      = mode_q.ilv;
   assign last_o     = last_w;
   assign stop_err_o = stop_err_q;
   assign cfg_err_o  = mode_q.err;

   // R6: finishing the final beat closes the burst
   a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_w && !susp_i && !start_i) |=> !active_q);

   // R8: stop closes a full-page burst
   a_r8_stop_page: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && mode_q.full && stop_i && !susp_i && !start_i) |=> !active_q);

   // R9: the illegal-stop pulse only follows a stop in a finite burst
   a_r9_err_finite: assert property (@(posedge clk) disable iff (!rst_n)
      stop_err_q |-> (!mode_q.full && $past(stop_i)));

   // R12: suspend freezes the sequence
   a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_i && active_q) |=> (active_q && $stable(beat_q) && $stable(base_q)));

endmodule

// File: rtl/colseq_map.sv
module colseq_map #(
   parameter int COL_W  = 10,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             active_i,
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] sel_low;

   assign seq_low = (base_i + beat_i) & mask_i;

   generate
      if (ILV_EN) begin : g_ilv
         logic [COL_W-1:0] ilv_low;
         assign ilv_low = (base_i ^ beat_i) & mask_i;
         assign sel_low = ilv_i ? ilv_low : seq_low;
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv_i;
         assign sel_low    = seq_low;
      end
   endgenerate

   assign col_o = active_i ? ((base_i & ~mask_i) | sel_low) : '0;

endmodule

// File: rtl/colseq_gen.sv
module colseq_gen
   import colseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int LEN_W  = 3,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             ilv_i,
   input  logic             wr_i,
   input  logic             single_wr_i,
   input  logic             stop_i,
   input  logic             susp_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             stop_err_o,
   output logic             cfg_err_o
);

   logic [COL_W-1:0] cfg_mask;
   burst_mode_t      cfg_mode;
   logic             act;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] mask;
   logic             ilv_eff;

   colseq_cfg #(.COL_W(COL_W), .LEN_W(LEN_W), .ILV_EN(ILV_EN)) u_cfg (
      .len_code_i  (len_code_i),
      .ilv_i       (ilv_i),
      .wr_i        (wr_i),
      .single_wr_i (single_wr_i),
      .mask_o      (cfg_mask),
      .mode_o      (cfg_mode)
   );

   colseq_ctl #(.COL_W(COL_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .mask_i      (cfg_mask),
      .mode_i      (cfg_mode),
      .stop_i      (stop_i),
      .susp_i      (susp_i),
      .active_o    (act),
      .beat_o      (beat),
      .base_o      (base),
      .mask_o      (mask),
      .ilv_o       (ilv_eff),
      .last_o      (last_o),
      .stop_err_o  (stop_err_o),
      .cfg_err_o   (cfg_err_o)
   );

   colseq_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .active_i (act),
      .base_i   (base),
      .beat_i   (beat),
      .mask_i   (mask),
      .ilv_i    (ilv_eff),
      .col_o    (col_o)
   );

   assign valid_o = act;

   // R1: an accepted start shows its column on the next cycle
   a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !susp_i) |=> (valid_o && col_o == $past(start_col_i)));

   // R6: last only while a beat is presented
   a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R12: the presented column holds while suspended
   a_r12_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_i && valid_o) |=> (valid_o && $stable(col_o)));

endmodule

// File: tb/colseq_gen_test.sv
`timescale 1ns/1ps
module colseq_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [9:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       wr_i = 1'b0;
   logic       single_wr_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       susp_i = 1'b0;
   logic [9:0] col_o;
   logic       valid_o, last_o, stop_err_o, cfg_err_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   colseq_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i),
      .single_wr_i(single_wr_i), .stop_i(stop_i), .susp_i(susp_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
      .stop_err_o(stop_err_o), .cfg_err_o(cfg_err_o)
   );

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int span(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         7: return 1024;
         default: return 1;
      endcase
   endfunction

   function automatic logic [31:0] expc(input int s, input int k, input int len, input bit ilv);
      int m, lo;
      if (len == 1024) return 32'((s + k) % 1024);
      m  = len - 1;
      lo = ilv ? ((s ^ k) & m) : ((s + k) & m);
      return 32'((s & ~m) | lo);
   endfunction

   task automatic burst(input string tag, input int s, input int code, input bit ilv,
                        input bit wr, input bit sw, input int len, input bit cerr);
      start_col_i = 10'(s); len_code_i = 3'(code); ilv_i = ilv;
      wr_i = wr; single_wr_i = sw; start_i = 1'b1;
      tick();
      start_i = 1'b0;
      for (int k = 0; k < len; k++) begin
         if (k == 0) begin
            chk("R1 valid", valid_o, 1);
            chk("R2 cfg_err", cfg_err_o, cerr);
         end
         chk(tag, col_o, expc(s, k, len, ilv));
         chk("R6 last", last_o, (k == len - 1));
         tick();
      end
      chk("R6 end", valid_o, 0);
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #35;
      // R13: reset state
      chk("R13 valid", valid_o, 0);
      chk("R13 last", last_o, 0);
      chk("R13 col", col_o, 0);
      chk("R13 stop_err", stop_err_o, 0);
      chk("R13 cfg_err", cfg_err_o, 0);
      rst_n = 1'b1;
      tick();

      // R2 R3 R4: sweep of finite and reserved codes
      for (int code = 0; code < 7; code++) begin
         for (int il = 0; il < 2; il++) begin
            for (int idx = 0; idx < 128; idx++) begin
               int s;
               s = (idx < 64) ? idx : 896 + idx;
               burst(code > 3 ? "R2 col" : (il != 0 ? "R4 col" : "R3 col"),
                     s, code, il[0], 1'b0, 1'b0, span(code), code > 3);
            end
         end
      end

      // R5 R8: full page wrap, then stop
      start_col_i = 10'd1020; len_code_i = 3'b111; ilv_i = 0; start_i = 1;
      tick();
      start_i = 0;
      for (int k = 0; k < 1030; k++) begin
         chk("R5 col", col_o, expc(1020, k, 1024, 0));
         chk("R5 last", last_o, 0);
         tick();
      end
      chk("R5 still valid", valid_o, 1);
      stop_i = 1;
      tick();
      stop_i = 0;
      chk("R8 stopped", valid_o, 0);
      chk("R8 no err", stop_err_o, 0);

      // R11: interleave with full page falls back to sequential
      start_col_i = 10'd5; len_code_i = 3'b111; ilv_i = 1; start_i = 1;
      tick();
      start_i = 0;
      chk("R11 cfg_err", cfg_err_o, 1);
      for (int k = 0; k < 6; k++) begin
         chk("R11 col", col_o, expc(5, k, 1024, 0));
         tick();
      end
      stop_i = 1;
      tick();
      stop_i = 0;
      chk("R11 stopped", valid_o, 0);

      // R9: stop in a finite burst is ignored and flagged
      start_col_i = 10'd5; len_code_i = 3'b011; ilv_i = 0; start_i = 1;
      tick();
      start_i = 0;
      tick();
      tick();
      chk("R9 beat2", col_o, expc(5, 2, 8, 0));
      stop_i = 1;
      tick();
      stop_i = 0;
      chk("R9 err pulse", stop_err_o, 1);
      chk("R9 continues", col_o, expc(5, 3, 8, 0));
      chk("R9 valid", valid_o, 1);
      tick();
      chk("R9 err cleared", stop_err_o, 0);
      for (int k = 4; k < 8; k++) begin
         chk("R9 col", col_o, expc(5, k, 8, 0));
         tick();
      end
      chk("R9 end", valid_o, 0);
      stop_i = 1;
      tick();
      stop_i = 0;
      chk("R9 idle stop", stop_err_o, 0);
      chk("R9 idle valid", valid_o, 0);

      // R7: restart in mid-burst
      start_col_i = 10'd9; len_code_i = 3'b010; ilv_i = 0; start_i = 1;
      tick();
      start_i = 0;
      tick();
      chk("R7 beat1", col_o, 10);
      start_col_i = 10'd22; ilv_i = 1; start_i = 1;
      tick();
      start_i = 0;
      for (int k = 0; k < 4; k++) begin
         chk("R7 col", col_o, expc(22, k, 4, 1));
         chk("R7 last", last_o, (k == 3));
         tick();
      end
      chk("R7 end", valid_o, 0);

      // R12: suspend freezes and ignores start/stop
      start_col_i = 10'd3; len_code_i = 3'b011; ilv_i = 0; start_i = 1;
      tick();
      start_i = 0;
      tick();
      tick();
      susp_i = 1; start_i = 1; start_col_i = 10'd100; stop_i = 1;
      for (int n = 0; n < 3; n++) begin
         tick();
         chk("R12 hold col", col_o, expc(3, 2, 8, 0));
         chk("R12 valid", valid_o, 1);
         chk("R12 no err", stop_err_o, 0);
      end
      susp_i = 0; start_i = 0; stop_i = 0;
      tick();
      for (int k = 3; k < 8; k++) begin
         chk("R12 resume", col_o, expc(3, k, 8, 0));
         tick();
      end
      chk("R12 end", valid_o, 0);

      // R10: single-write mode
      burst("R10 write", 40, 3, 1'b0, 1'b1, 1'b1, 1, 1'b0);
      burst("R10 read", 40, 3, 1'b0, 1'b0, 1'b1, 8, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule